// File: doc/BRIEF.md
# Byte-Lane Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt to a processor, along with a vector number. Software sets it up through two byte-wide ports on one 16-bit word. The low byte lane (`bus_lane[0]`, data bits 7:0) is the command port. The high byte lane (`bus_lane[1]`, data bits 15:8) is the data port.

The block keeps three registers:
- a request register, which samples the request lines each cycle;
- an in-service register;
- a mask register.

Line 0 has the highest priority and line 7 the lowest. The processor acknowledges the interrupt that is being presented, and that line then moves into service. While a line is in service, it blocks its own line and every line of lower priority. A non-specific end-of-interrupt command releases the highest-priority line in service.

Software must write three setup words before any interrupt is raised:
1. a command byte with bit 4 set;
2. a data byte that holds the vector base;
3. one more data byte.

After that, data-port writes load the mask. Command bytes select whether command-port reads return the request register or the in-service register, or they issue the end-of-interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, `vector` is 0 and `bus_rdata` is 0. After the setup sequence, with no request active, `irq_out` stays 0 and `vector` stays 0.
- R2: An access happens in a cycle with `bus_cs` and `bus_stb` high. `bus_we` = 1 means a write and `bus_we` = 0 means a read. A read latches `bus_rdata` at the clock edge that ends the access, and the value holds until the next read. Byte 7:0 carries the selected command-port register when `bus_lane[0]` is set and 0 otherwise. Byte 15:8 carries the mask when `bus_lane[1]` is set and 0 otherwise. If a write selects both lanes, only the command byte takes effect.
- R3: A command byte with bit 4 set starts setup. It clears the mask and the in-service register, and it selects the request register for reads. The next data byte sets the vector base, and the data byte after that completes setup. `irq_out` stays 0 until setup is complete.
- R4: After setup, a data-port write loads the mask. A mask bit of 1 stops the matching line from raising `irq_out`.
- R5: `vector` equals the base plus the number of the presented line. Base bits 2:0 are ignored, so a base of 0x08 with line 3 gives 11.
- R6: Priority is fixed and line 0 is the highest. If lines 0 and 3 are both pending, the vector shows line 0.
- R7: Command 0x0A selects the request register for reads of the low lane, and command 0x0B selects the in-service register. The request register holds the request levels from the previous cycle.
- R8: A change on `req_in` appears on `irq_out` and `vector` two clock edges later.
- R9: When `ack` is high while `irq_out` is high, the presented line's in-service bit is set at that edge and `irq_out` is 0 after it. When `ack` is high while `irq_out` is low, it has no effect.
- R10: `irq_out` is raised only when the highest-priority unmasked pending line has strictly higher priority than the highest-priority in-service bit.
- R11: Command 0x20 clears the lowest-numbered set bit of the in-service register. After that, the same line can be presented again.
- R12: If an end-of-interrupt and a taken acknowledge fall on the same edge, the clear uses the in-service register as it was before that edge, and the acknowledged bit is then set.
- R13: `vector` is 0 whenever `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_cs | input | 1 | Chip select |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_lane | input | 2 | Byte lane selects: bit 0 = command port, bit 1 = data port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| req_in | input | 8 | Interrupt request levels |
| ack | input | 1 | Interrupt acknowledge |
| irq_out | output | 1 | Interrupt to processor |
| vector | output | 8 | Vector of presented line |

## Verification
The case of interest is an end-of-interrupt command and a taken acknowledge landing on the same edge. Both of them rewrite the in-service register.

The directed test sets this up as follows:
1. Line 3 is placed in service.
2. Line 0 is raised, so it is presented over line 3.
3. In one cycle, the bench writes 0x20 and raises `ack`.

The in-service register is then read back and must be 0x01. The random phase issues end-of-interrupt writes and acknowledges independently, so the two often coincide. A bench model that applies R12 judges every such cycle through `irq_out`, `vector` and reads of the in-service register.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_stb,
  input  logic        bus_we,
  input  logic [1:0]  bus_lane,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [7:0]  req_in,
  input  logic        ack,
  output logic        irq_out,
  output logic [7:0]  vector
);
  localparam int LINES = 8;
  localparam int LW = $clog2(LINES);

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_TAIL, S_RUN} st_t;

  st_t st;
  logic [LINES-1:0] irr, isr, mask;
  logic [7-LW:0] base;
  logic [LW-1:0] cur;
  logic rsel;

  function automatic logic [LW-1:0] top_idx(input logic [LINES-1:0] v);
    top_idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) top_idx = i[LW-1:0];
  endfunction

  wire [7:0] cmd = bus_wdata[7:0];
  wire [7:0] dat = bus_wdata[15:8];
  wire wr = bus_cs & bus_stb & bus_we;
  wire rd = bus_cs & bus_stb & ~bus_we;
  wire cmd_wr = wr & bus_lane[0];
  wire dat_wr = wr & bus_lane[1] & ~bus_lane[0];
  wire run = (st == S_RUN);
  wire init_w = cmd_wr & cmd[4];
  wire ocw3 = cmd_wr & run & (cmd[4:3] == 2'b01) & ~cmd[2] & cmd[1];
  wire eoi = cmd_wr & run & (cmd[4:3] == 2'b00) & (cmd[7:5] == 3'b001);
  wire take = ack & irq_out;

  wire [LINES-1:0] pend = irr & ~mask;
  wire [LW-1:0] pidx = top_idx(pend);
  wire [LW-1:0] sidx = top_idx(isr);
  wire win = run & (|pend) & (~(|isr) | (pidx < sidx));
  wire [LINES-1:0] eoi_clr = eoi ? (isr & (~isr + 1'b1)) : '0;
  wire [LINES-1:0] isr_set = take ? (LINES'(1) << cur) : '0;

  assign vector = irq_out ? {base, cur} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      irr <= '0;
      isr <= '0;
      mask <= '0;
      base <= '0;
      cur <= '0;
      rsel <= 1'b0;
      irq_out <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irr <= req_in;
      irq_out <= win & ~take;
      cur <= pidx;
      if (rd)
        bus_rdata <= {bus_lane[1] ? mask : 8'h00,
                      bus_lane[0] ? (rsel ? isr : irr) : 8'h00};
      if (init_w) begin
        st <= S_BASE;
        mask <= '0;
        isr <= '0;
        rsel <= 1'b0;
      end else begin
        isr <= (isr & ~eoi_clr) | isr_set;
        if (ocw3) rsel <= cmd[0];
        if (dat_wr) begin
          case (st)
            S_BASE: begin base <= dat[7:LW]; st <= S_TAIL; end
            S_TAIL: st <= S_RUN;
            S_RUN:  mask <= dat;
            default: ;
          endcase
        end
      end
    end
  end

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq_out);

  // R9
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !init_w) |=> isr[$past(cur)]);

  // R11
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !take && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R3
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |=> !irq_out);

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_stb = 0, bus_we = 0, ack = 0;
  logic [1:0] bus_lane = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [7:0] req_in = 0, vector;
  logic irq_out;

  int checks = 0, failures = 0;
  logic [7:0] cur_req = 0;

  logic [1:0] m_st = 0;
  logic [7:0] m_irr = 0, m_isr = 0, m_mask = 0, m_base = 0;
  logic [2:0] m_cur = 0;
  logic m_irq = 0, m_rsel = 0;
  logic [15:0] m_rd = 0;

  prio_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_lane(bus_lane), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_in(req_in), .ack(ack), .irq_out(irq_out), .vector(vector));

  always #5 clk = ~clk;

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [2:0] m_top(input logic [7:0] v);
    m_top = 0;
    for (int i = 7; i >= 0; i--) if (v[i]) m_top = 3'(i);
  endfunction

  function automatic logic [7:0] m_low(input logic [7:0] v);
    m_low = 0;
    for (int i = 7; i >= 0; i--) if (v[i]) m_low = 8'(1 << i);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 none, 1 write, 2 read
  task automatic cyc(input logic [7:0] r, input logic a, input int op,
                     input logic [1:0] ln, input logic [15:0] wd);
    logic [7:0] pend, nisr, cmdb, datb;
    logic win, take, eoi, initw, cw, dw;
    req_in = r; ack = a;
    bus_cs = (op != 0); bus_stb = (op != 0); bus_we = (op == 1);
    bus_lane = ln; bus_wdata = wd;
    @(posedge clk);
    cmdb = wd[7:0]; datb = wd[15:8];
    cw = (op == 1) && ln[0];
    dw = (op == 1) && ln[1] && !ln[0];
    initw = cw && cmdb[4];
    eoi = cw && m_st == 3 && cmdb == 8'h20;
    pend = m_irr & ~m_mask;
    win = (m_st == 3) && pend != 0 && (m_isr == 0 || m_top(pend) < m_top(m_isr));
    take = a && m_irq;
    if (op == 2) m_rd = {ln[1] ? m_mask : 8'h00, ln[0] ? (m_rsel ? m_isr : m_irr) : 8'h00};
    nisr = (m_isr & ~(eoi ? m_low(m_isr) : 8'h00)) | (take ? 8'(1 << m_cur) : 8'h00);
    m_irq = win && !take;
    m_cur = m_top(pend);
    m_irr = r;
    if (initw) begin
      m_st = 1; m_mask = 0; m_isr = 0; m_rsel = 0;
    end else begin
      m_isr = nisr;
      if (cw && m_st == 3 && (cmdb == 8'h0A || cmdb == 8'h0B)) m_rsel = cmdb[0];
      if (dw) begin
        if (m_st == 1) begin m_base = datb; m_st = 2; end
        else if (m_st == 2) m_st = 3;
        else if (m_st == 3) m_mask = datb;
      end
    end
    @(negedge clk);
    bus_cs = 0; bus_stb = 0; bus_we = 0; ack = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(cur_req, 0, 0, 2'b00, 16'h0);
  endtask
  task automatic wcmd(input logic [7:0] b); cyc(cur_req, 0, 1, 2'b01, {8'h00, b}); endtask
  task automatic wdat(input logic [7:0] b); cyc(cur_req, 0, 1, 2'b10, {b, 8'h00}); endtask
  task automatic rdl(input logic [1:0] ln); cyc(cur_req, 0, 2, ln, 16'h0); endtask
  task automatic do_ack(); cyc(cur_req, 1, 0, 2'b00, 16'h0); endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset irq", 16'(irq_out), 0);
    check("R1 reset vector", 16'(vector), 0);
    check("R1 reset rdata", bus_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    cur_req = 8'h08; idle(3);
    check("R3 no irq before setup", 16'(irq_out), 0);
    wcmd(8'h13); wdat(8'h08); idle(1);
    check("R3 no irq mid setup", 16'(irq_out), 0);
    cur_req = 8'h00; idle(2);
    wdat(8'h01); idle(3);
    check("R1 idle irq", 16'(irq_out), 0);
    check("R1 idle vector", 16'(vector), 0);
    rdl(2'b10);
    check("R3 mask cleared", bus_rdata, 16'h0000);

    wdat(8'hFF); cur_req = 8'h08; idle(3);
    check("R4 masked line", 16'(irq_out), 0);
    rdl(2'b10);
    check("R2 mask readback high lane", bus_rdata, 16'hFF00);
    idle(1);
    check("R2 rdata held", bus_rdata, 16'hFF00);

    cur_req = 8'h00; wdat(8'h00); idle(2);
    cur_req = 8'h08; idle(1);
    check("R8 one edge after request", 16'(irq_out), 0);
    idle(1);
    check("R8 two edges irq", 16'(irq_out), 1);
    check("R5 vector line 3", 16'(vector), 11);
    check("R13 vector while high", 16'(vector), 16'(m_base + 8'd3));

    cur_req = 8'h09; idle(2);
    check("R6 line 0 wins", 16'(vector), 8);
    wcmd(8'h0A); rdl(2'b01);
    check("R7 irr", bus_rdata, 16'h0009);
    wcmd(8'h0B); rdl(2'b11);
    check("R7 isr empty", bus_rdata, 16'h0000);

    do_ack();
    check("R9 irq drops after ack", 16'(irq_out), 0);
    check("R13 vector zero", 16'(vector), 0);
    rdl(2'b01);
    check("R9 isr line 0", bus_rdata, 16'h0001);
    cur_req = 8'h08; idle(4);
    check("R10 lower blocked", 16'(irq_out), 0);
    do_ack(); rdl(2'b01);
    check("R9 ack while low ignored", bus_rdata, 16'h0001);

    wcmd(8'h20); idle(2);
    check("R11 line 3 after eoi", 16'(irq_out), 1);
    check("R11 vector 11", 16'(vector), 11);
    do_ack();
    cur_req = 8'h88; idle(4);
    check("R10 line 7 blocked", 16'(irq_out), 0);
    cur_req = 8'h89; idle(2);
    check("R10 higher taken", 16'(irq_out), 1);
    check("R10 higher vector", 16'(vector), 8);
    cyc(cur_req, 1, 1, 2'b01, 16'h0020);
    rdl(2'b01);
    check("R12 eoi with ack", bus_rdata, 16'h0001);
    cur_req = 8'h00; wcmd(8'h20); idle(2);
    check("R11 idle after eoi", 16'(irq_out), 0);

    wcmd(8'h11); wdat(8'h40); wdat(8'h01); idle(2);
    void'($urandom(1234));
    for (int n = 0; n < 4000; n++) begin
      int act;
      logic a;
      if ($urandom % 4 == 0) cur_req = 8'($urandom) & 8'($urandom);
      a = m_irq ? ($urandom % 2 == 1) : ($urandom % 8 == 0);
      act = $urandom % 20;
      if (act < 2) cyc(cur_req, a, 1, 2'b01, 16'h0020);
      else if (act == 2) cyc(cur_req, a, 1, 2'b10, {8'($urandom) & 8'($urandom) & 8'($urandom), 8'h00});
      else if (act == 3) cyc(cur_req, a, 1, 2'b01, {8'h00, ($urandom % 2) ? 8'h0B : 8'h0A});
      else if (act < 6) cyc(cur_req, a, 2, 2'($urandom), 16'h0);
      else cyc(cur_req, a, 0, 2'b00, 16'h0);
      check("R10 random irq", 16'(irq_out), 16'(m_irq));
      check("R5 random vector", 16'(vector), m_irq ? 16'(m_base + 8'(m_cur)) : 16'h0);
      check("R12 random rdata", bus_rdata, m_rd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule